// File: doc/BRIEF.md
# Banked Indexed Register Port

This block is the host-facing front end of a display controller's configuration registers. An 8-bit I/O bus reaches five banks of byte-wide registers through a handful of port addresses. Four banks are ordinary: the even address of a pair latches a register number, and the odd address reads or writes the register that number points at. The fifth bank, for attribute settings, has a single port address that takes a register number on one write and data on the next. A hidden phase bit steers those writes. A read of the status address returns that bit to the register-number phase.

Software syncs the phase by reading status before it touches the attribute port. It then writes a register number, and then either writes the data to the same address or reads the data back from the following address. Bit 5 of the byte written as the attribute register number is kept as a separate video-enable output. All storage sits behind a flat array with a fixed number of implemented registers per bank.

Port map (4-bit `addr`): 0/1 bank A number/data, 2/3 bank B, 4/5 bank C, 6/7 bank D, 8 attribute port, 9 attribute data read, 10 status. Addresses 11 to 15 are unmapped.

Top module: `regport_top`

## Requirements
- R1: After reset, every register, every register number and the video-enable flag are zero, and the attribute port is in the register-number phase.
- R2: A write to an even address 0, 2, 4 or 6 stores the low 7 bits of `wrData` as that bank's register number. A read of the same address returns `{1'b0, number}`.
- R3: A write to the odd address that follows an even address stores the byte into the bank register currently selected. A read of that odd address returns the register's contents in the same cycle as `rdEn`.
- R4: Each bank has its own register number and storage, so equal numbers in different banks reach different registers.
- R5: Writes to address 8 alternate. A write in the number phase stores `wrData[4:0]` as the attribute register number. A write in the data phase stores the byte into the selected attribute register. Every write to address 8 flips the phase.
- R6: A read of address 10 returns zero and puts the attribute port back into the number phase.
- R7: A read of address 9 returns the selected attribute register. A read of address 8 returns `{2'b0, videoEn, number[4:0]}` and does not change the phase.
- R8: A number-phase write to address 8 copies `wrData[5]` to `videoEn`. Data-phase writes and all other accesses leave `videoEn` unchanged.
- R9: Ordinary banks implement numbers 0 to REGS_PER_BANK-1 (default 32). The attribute bank implements 0 to ATTR_REGS-1 (default 21). Data reads at a higher number return zero, and data writes there change no register, including the register whose number is equal in the low bits.
- R10: Writes to addresses 9 to 15 change no register and do not flip the attribute phase. Reads of addresses 11 to 15 return zero.
- R11: `rdData` is zero in any cycle where `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W (4) | Port address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid in the cycle of `rdEn` |
| videoEn | output | 1 | Video-enable flag taken from bit 5 of the attribute register number |

## Verification
Ordinary banks are driven with interleaved number and data writes that reuse one register number across two banks. These show whether storage is separated per bank or shared. The attribute port is driven through number/data/number sequences, with status reads placed both between complete pairs and in the middle of a pair. This shows whether the phase flips on each write and clears only on a status read. Numbers beyond the implemented range, and numbers that alias in their low bits, show whether the range guard blocks the write or just truncates the number. Writes to read-only and unmapped addresses placed inside an attribute pair show whether they leak into the phase bit.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int NUM_BANKS  = 5;
  localparam int ATTR_BANK  = 4;
  localparam int IDX_W      = 7;
  localparam int ATTR_IDX_W = 5;
  localparam int VIDEO_BIT  = 5;

  localparam int PORT_ATTR    = 8;
  localparam int PORT_ATTR_RD = 9;
  localparam int PORT_STATUS  = 10;

  typedef struct packed {
    logic [NUM_BANKS-1:0] idxWe;
    logic [NUM_BANKS-1:0] dataWe;
    logic [NUM_BANKS-1:0] idxRdSel;
    logic [NUM_BANKS-1:0] dataRdSel;
  } portStrobe_t;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strobes
);
  logic dataPhase;
  logic atPort;
  logic atRdPort;
  logic statusHit;

  assign atPort    = (addr == ADDR_W'(PORT_ATTR));
  assign atRdPort  = (addr == ADDR_W'(PORT_ATTR_RD));
  assign statusHit = rdEn && (addr == ADDR_W'(PORT_STATUS));

  always_comb begin
    strobes = '0;
    for (int b = 0; b < ATTR_BANK; b++) begin
      if (addr == ADDR_W'(2 * b)) begin
        strobes.idxWe[b]    = wrEn;
        strobes.idxRdSel[b] = rdEn;
      end
      if (addr == ADDR_W'(2 * b + 1)) begin
        strobes.dataWe[b]    = wrEn;
        strobes.dataRdSel[b] = rdEn;
      end
    end
    strobes.idxWe[ATTR_BANK]     = wrEn && atPort && !dataPhase;
    strobes.dataWe[ATTR_BANK]    = wrEn && atPort && dataPhase;
    strobes.idxRdSel[ATTR_BANK]  = rdEn && atPort;
    strobes.dataRdSel[ATTR_BANK] = rdEn && atRdPort;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                dataPhase <= 1'b0;
    else if (statusHit)       dataPhase <= 1'b0;
    else if (wrEn && atPort)  dataPhase <= !dataPhase;
  end

  // R6: a status read leaves the attribute port in the number phase
  assert_status_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusHit |=> !dataPhase);

  // R5: every attribute-port write flips the phase
  assert_phase_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atPort) |=> (dataPhase != $past(dataPhase)));

  // R10: at most one register-changing strobe per cycle
  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.idxWe, strobes.dataWe}));
endmodule

// File: rtl/regport_datapath.sv
module regport_datapath
  import regport_pkg::*;
#(
  parameter int REGS_PER_BANK = 32,
  parameter int ATTR_REGS     = 21
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t strobes,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        videoEn
);
  localparam int MEM_AW = $clog2(REGS_PER_BANK);

  logic [IDX_W-1:0]     idxReg  [NUM_BANKS];
  logic [7:0]           mem     [NUM_BANKS][REGS_PER_BANK];
  logic [NUM_BANKS-1:0] inRange;

  function automatic int bankLimit(input int b);
    return (b == ATTR_BANK) ? ATTR_REGS : REGS_PER_BANK;
  endfunction

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      inRange[b] = int'(idxReg[b]) < bankLimit(b);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      videoEn <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        idxReg[b] <= '0;
        for (int i = 0; i < REGS_PER_BANK; i++) mem[b][i] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobes.idxWe[b])
          idxReg[b] <= (b == ATTR_BANK) ? {2'b00, wrData[ATTR_IDX_W-1:0]}
                                        : wrData[IDX_W-1:0];
        if (strobes.dataWe[b] && inRange[b])
          mem[b][idxReg[b][MEM_AW-1:0]] <= wrData;
      end
      if (strobes.idxWe[ATTR_BANK]) videoEn <= wrData[VIDEO_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.idxRdSel[b])
        rdData = (b == ATTR_BANK) ? {2'b00, videoEn, idxReg[b][ATTR_IDX_W-1:0]}
                                  : {1'b0, idxReg[b]};
      if (strobes.dataRdSel[b] && inRange[b])
        rdData = mem[b][idxReg[b][MEM_AW-1:0]];
    end
  end

  // R8: video flag only moves on a number-phase attribute write
  assert_video_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.idxWe[ATTR_BANK] |=> $stable(videoEn));

  // R11: no read select, no data on the bus
  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.idxRdSel == '0 && strobes.dataRdSel == '0) |-> (rdData == 8'h00));

  for (genvar gb = 0; gb < ATTR_BANK; gb++) begin : g_idxChk
    // R2: ordinary number write lands the low 7 bits
    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.idxWe[gb] |=> (idxReg[gb] == $past(wrData[IDX_W-1:0])));
  end
endmodule

// File: rtl/regport_top.sv
module regport_top
  import regport_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int REGS_PER_BANK = 32,
  parameter int ATTR_REGS     = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              videoEn
);
  portStrobe_t strobes;

  regport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .strobes(strobes)
  );

  regport_datapath #(.REGS_PER_BANK(REGS_PER_BANK), .ATTR_REGS(ATTR_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .videoEn(videoEn)
  );
endmodule

// File: tb/sim_regport_top.sv
module sim_regport_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       videoEn;

  int checks = 0;
  int fails  = 0;

  always #2 clk = !clk;

  regport_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .videoEn(videoEn)
  );

  // {isRead, addr, data-or-expected, requirement number}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd4,  8'h05, 4'd3},  // bank C number 5
    {1'b0, 4'd5,  8'hA7, 4'd3},
    {1'b1, 4'd4,  8'h05, 4'd2},  // R2
    {1'b1, 4'd5,  8'hA7, 4'd3},  // R3
    {1'b0, 4'd0,  8'h05, 4'd4},
    {1'b1, 4'd1,  8'h00, 4'd4},  // R4 bank A reg 5 untouched
    {1'b0, 4'd1,  8'h3C, 4'd3},
    {1'b1, 4'd1,  8'h3C, 4'd3},
    {1'b1, 4'd5,  8'hA7, 4'd4},
    {1'b0, 4'd2,  8'h85, 4'd2},  // bit 7 dropped
    {1'b1, 4'd2,  8'h05, 4'd2},
    {1'b1, 4'd10, 8'h00, 4'd6},  // R6 status
    {1'b0, 4'd8,  8'h23, 4'd5},  // attr number 3, video on
    {1'b0, 4'd8,  8'h5A, 4'd5},
    {1'b1, 4'd8,  8'h23, 4'd7},  // R7
    {1'b1, 4'd9,  8'h5A, 4'd7},
    {1'b0, 4'd8,  8'h04, 4'd5},  // R5 number phase again
    {1'b1, 4'd8,  8'h04, 4'd8},  // R8 video off
    {1'b0, 4'd8,  8'h66, 4'd5},
    {1'b1, 4'd9,  8'h66, 4'd5},
    {1'b0, 4'd8,  8'h03, 4'd7},
    {1'b1, 4'd9,  8'h5A, 4'd7},
    {1'b0, 4'd4,  8'h40, 4'd9},  // R9 number 64 out of range
    {1'b0, 4'd5,  8'h99, 4'd9},
    {1'b1, 4'd5,  8'h00, 4'd9},
    {1'b0, 4'd4,  8'h00, 4'd9},  // aliasing reg 0 stays 0
    {1'b1, 4'd5,  8'h00, 4'd9},
    {1'b1, 4'd12, 8'h00, 4'd10}  // R10 unmapped read
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 check(req, rdData, exp);
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: got hang expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check("R1 video", {7'b0, videoEn}, 8'h00);
    rd(4'd1, 8'h00, "R1");
    rd(4'd6, 8'h00, "R1");
    rd(4'd8, 8'h00, "R1");
    wr(4'd8, 8'h02);           // first attr write after reset is a number
    rd(4'd8, 8'h02, "R1");
    rd(4'd10, 8'h00, "R6");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16])
        rd(VEC[i][15:12], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
      else
        wr(VEC[i][15:12], VEC[i][11:4]);
    end

    // R8: video flag follows number writes only
    rd(4'd10, 8'h00, "R6");
    wr(4'd8, 8'h20);
    check("R8 set", {7'b0, videoEn}, 8'h01);
    wr(4'd8, 8'h00);           // data phase, reg 0
    check("R8 hold", {7'b0, videoEn}, 8'h01);
    wr(4'd8, 8'h00);
    check("R8 clear", {7'b0, videoEn}, 8'h00);

    // R6: status read in the middle of a pair
    rd(4'd10, 8'h00, "R6");
    wr(4'd8, 8'h02);
    rd(4'd10, 8'h00, "R6");
    wr(4'd8, 8'h07);           // taken as number
    rd(4'd8, 8'h07, "R6");
    wr(4'd8, 8'h02);           // data into reg 7? no: phase now data -> reg 7
    rd(4'd9, 8'h02, "R6");

    // R9: attribute number beyond range
    rd(4'd10, 8'h00, "R6");
    wr(4'd8, 8'h15);
    wr(4'd8, 8'hFF);
    rd(4'd9, 8'h00, "R9");

    // R10: read-only and unmapped writes leave phase and storage alone
    rd(4'd10, 8'h00, "R6");
    wr(4'd8, 8'h01);
    wr(4'd9, 8'hEE);
    wr(4'd10, 8'hEE);
    wr(4'd15, 8'hEE);
    wr(4'd8, 8'h77);           // still the data write
    rd(4'd9, 8'h77, "R10");
    rd(4'd8, 8'h01, "R10");

    // R11: no read strobe, no data
    @(negedge clk);
    addr = 4'd9;
    #1 check("R11", rdData, 8'h00);

    finishRun();
  end
endmodule